// File: doc/BRIEF.md
# Scaler Phase Parameter Calculator

This block turns one plane's scaling request into the parameters that a polyphase scaling engine loads before a frame. The request is a source rectangle in U16.16 fixed point, a destination size in whole pixels, a rotation flag and a plane-select mask. From these the block works out the horizontal and vertical upscale factors (U16.16), the initial phase and the phase increment for each axis, the effective input size, the output size and an enhancer enable bit.

A request is accepted on a `start` pulse while the block is idle. If no plane is selected, the block reports completion at once with scaling disabled. If more than one plane is selected, or a dimension that would be used as a divisor is zero, it reports an error at once. Otherwise one restoring divider, producing one quotient bit per cycle, performs all six divisions in turn, and `done` follows `start` after a fixed number of cycles. All results are registered and hold until the next accepted `start`.

Top module: `scaler_phase_calc`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `scale_en` and `enh_en` are 0.
- R2: A `start` with `plane_mask` all zero gives `done` in the next cycle, with `scale_en`=0, `err`=0 and all result outputs 0, whatever the dimensions.
- R3: A `start` with two or more bits of `plane_mask` set gives `done` and `err`=1 in the next cycle, with `scale_en`=0.
- R4: A `start` with exactly one mask bit set but `src_w`, `src_h`, `dst_w` or `dst_h` equal to zero gives `done` and `err`=1 in the next cycle, with `scale_en`=0.
- R5: `h_up` = low 32 bits of (`dst_w` << 32) / `src_w`, `v_up` likewise from `dst_h` and `src_h` (U16.16, integer part in bits 31:16).
- R6: With `rotate`=0, `in_w` = `src_w`[31:16] and `in_h` = `src_h`[31:16]; with `rotate`=1, `in_w` = `src_h`[31:16] and `in_h` = `src_w`[31:16].
- R7: `h_init` = (((`in_w` << 4) / `out_w`) + 1) / 2 and `v_init` likewise from `in_h` and `out_h`.
- R8: `h_step` = (`in_w` << 16) / `out_w` and `v_step` likewise from `in_h` and `out_h`.
- R9: `enh_en` is 1 exactly when the integer part of `h_up` or of `v_up` is 2 or more.
- R10: On a valid request, `out_w`=`dst_w`, `out_h`=`dst_h`, `scale_en`=1 and `err`=0 when `done` rises.
- R11: On a valid request `busy` is high from the cycle after `start` and `done` is a one-cycle pulse exactly 6*(DW+34) cycles after the edge that accepts `start` (300 for DW=16), with `busy` low in that cycle.
- R12: A `start` while `busy` is high is ignored: the running request completes with its own results and latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, taken while idle |
| plane_mask | input | NPL | One bit per plane asking for scaling |
| rotate | input | 1 | Source is rotated by 90 or 270 degrees |
| src_w | input | DW+16 | Source width, U16.16 |
| src_h | input | DW+16 | Source height, U16.16 |
| dst_w | input | DW | Destination width in pixels |
| dst_h | input | DW | Destination height in pixels |
| busy | output | 1 | Divisions in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request was rejected |
| scale_en | output | 1 | Last request produced scaling parameters |
| enh_en | output | 1 | Enhancer enable |
| h_up | output | 32 | Horizontal upscale factor, U16.16 |
| v_up | output | 32 | Vertical upscale factor, U16.16 |
| h_init | output | DW+4 | Horizontal initial phase |
| v_init | output | DW+4 | Vertical initial phase |
| h_step | output | DW+16 | Horizontal phase increment |
| v_step | output | DW+16 | Vertical phase increment |
| in_w | output | DW | Effective input width |
| in_h | output | DW | Effective input height |
| out_w | output | DW | Output width |
| out_h | output | DW | Output height |

## Verification
The two functions that can meet in one cycle are the completion of a request and the acceptance of the next one: the bench raises `start` for a new request in the very cycle `done` is high, so the old results are read in that cycle while the new request is latched at its closing edge. Each chained request is then judged on its own latency and on every result against bench arithmetic. The bench also pulses `start` with different inputs in the middle of a run, and expects the run's results and latency to match the first request only.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Division order inside one request
  typedef enum logic [2:0] {
    OP_HUP   = 3'd0,
    OP_VUP   = 3'd1,
    OP_HINIT = 3'd2,
    OP_HSTEP = 3'd3,
    OP_VINIT = 3'd4,
    OP_VSTEP = 3'd5
  } op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } st_e;

  localparam int NUM_DIV = 6;
endpackage

// File: rtl/scp_divider.sv
// Restoring divider, one quotient bit per cycle, fixed NW-cycle run.
module scp_divider #(
  parameter int NW  = 48,
  parameter int DSW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ld,
  input  logic [NW-1:0]  dividend,
  input  logic [DSW-1:0] divisor,
  output logic           fin,
  output logic [NW-1:0]  quo
);
  localparam int CW = $clog2(NW + 1);

  logic [DSW-1:0] rem;
  logic [DSW-1:0] dsr;
  logic [CW-1:0]  cnt;
  logic           run;
  logic [DSW:0]   shifted;
  logic           ge;
  logic [DSW:0]   diff;

  always_comb begin
    shifted = {rem, quo[NW-1]};
    ge      = (shifted >= {1'b0, dsr});
    diff    = shifted - {1'b0, dsr};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem <= '0;
      dsr <= '0;
      quo <= '0;
      cnt <= '0;
      run <= 1'b0;
      fin <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (ld) begin
        rem <= '0;
        quo <= dividend;
        dsr <= divisor;
        cnt <= CW'(NW);
        run <= 1'b1;
      end else if (run) begin
        rem <= ge ? diff[DSW-1:0] : shifted[DSW-1:0];
        quo <= {quo[NW-2:0], ge};
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  // Partial remainder never reaches the divisor while a division runs
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (rem < dsr)); // R5

  // Completion is a single-cycle pulse
  AST_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin); // R11
endmodule

// File: rtl/scp_req_check.sv
// Classifies a request: no plane selected, or not acceptable.
module scp_req_check #(
  parameter int NPL   = 4,
  parameter int DW    = 16,
  parameter int SRC_W = 32
) (
  input  logic [NPL-1:0]   mask,
  input  logic [SRC_W-1:0] src_w,
  input  logic [SRC_W-1:0] src_h,
  input  logic [DW-1:0]    dst_w,
  input  logic [DW-1:0]    dst_h,
  output logic             off,
  output logic             bad
);
  logic multi;
  logic zero_dim;

  always_comb begin
    off      = (mask == '0);
    multi    = |(mask & (mask - 1'b1));
    zero_dim = (src_w == '0) || (src_h == '0) || (dst_w == '0) || (dst_h == '0);
    bad      = multi || zero_dim;
  end
endmodule

// File: rtl/scp_opnd_sel.sv
// Picks dividend and divisor for the current division step.
module scp_opnd_sel
  import scp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int FRAC    = 16,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12
) (
  input  scp_pkg::op_e               op,
  input  logic [DW+FRAC-1:0]         src_w,
  input  logic [DW+FRAC-1:0]         src_h,
  input  logic [DW-1:0]              dst_w,
  input  logic [DW-1:0]              dst_h,
  input  logic [DW-1:0]              in_w,
  input  logic [DW-1:0]              in_h,
  output logic [DW+2*FRAC-1:0]       dvd,
  output logic [DW+FRAC-1:0]         dsr
);
  localparam int NW     = DW + 2*FRAC;
  localparam int INIT_W = DW + PH_BITS;
  localparam int STEP_W = DW + PH_BITS + PH_FRAC;
  localparam int SH_ST  = PH_BITS + PH_FRAC;

  always_comb begin
    dvd = '0;
    dsr = '0;
    unique case (op)
      OP_HUP: begin
        dvd = {dst_w, {(2*FRAC){1'b0}}};
        dsr = src_w;
      end
      OP_VUP: begin
        dvd = {dst_h, {(2*FRAC){1'b0}}};
        dsr = src_h;
      end
      OP_HINIT: begin
        dvd[INIT_W-1:0] = {in_w, {PH_BITS{1'b0}}};
        dsr[DW-1:0]     = dst_w;
      end
      OP_HSTEP: begin
        dvd[STEP_W-1:0] = {in_w, {SH_ST{1'b0}}};
        dsr[DW-1:0]     = dst_w;
      end
      OP_VINIT: begin
        dvd[INIT_W-1:0] = {in_h, {PH_BITS{1'b0}}};
        dsr[DW-1:0]     = dst_h;
      end
      OP_VSTEP: begin
        dvd[STEP_W-1:0] = {in_h, {SH_ST{1'b0}}};
        dsr[DW-1:0]     = dst_h;
      end
      default: begin
        dvd = '0;
        dsr = '0;
      end
    endcase
  end

  // Step dividend must fit the shared divider
  AST_STEP_FITS: assert final (STEP_W <= NW); // R8
endmodule

// File: rtl/scaler_phase_calc.sv
module scaler_phase_calc
  import scp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int NPL     = 4,
  parameter int FRAC    = 16,
  parameter int PH_BITS = 4,
  parameter int PH_FRAC = 12
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [NPL-1:0]                plane_mask,
  input  logic                          rotate,
  input  logic [DW+FRAC-1:0]            src_w,
  input  logic [DW+FRAC-1:0]            src_h,
  input  logic [DW-1:0]                 dst_w,
  input  logic [DW-1:0]                 dst_h,
  output logic                          busy,
  output logic                          done,
  output logic                          err,
  output logic                          scale_en,
  output logic                          enh_en,
  output logic [2*FRAC-1:0]             h_up,
  output logic [2*FRAC-1:0]             v_up,
  output logic [DW+PH_BITS-1:0]         h_init,
  output logic [DW+PH_BITS-1:0]         v_init,
  output logic [DW+PH_BITS+PH_FRAC-1:0] h_step,
  output logic [DW+PH_BITS+PH_FRAC-1:0] v_step,
  output logic [DW-1:0]                 in_w,
  output logic [DW-1:0]                 in_h,
  output logic [DW-1:0]                 out_w,
  output logic [DW-1:0]                 out_h
);
  localparam int SRC_W  = DW + FRAC;
  localparam int NW     = DW + 2*FRAC;
  localparam int UP_W   = 2*FRAC;
  localparam int INIT_W = DW + PH_BITS;
  localparam int STEP_W = DW + PH_BITS + PH_FRAC;
  localparam int LAT    = NUM_DIV * (NW + 2);
  localparam int LCW    = $clog2(LAT + 2);
  localparam logic [UP_W-FRAC-1:0] ENH_MIN = 2;

  st_e              st;
  op_e              op;
  logic [SRC_W-1:0] r_src_w, r_src_h;
  logic             div_ld;
  logic             div_fin;
  logic [NW-1:0]    div_q;
  logic [NW-1:0]    dvd;
  logic [SRC_W-1:0] dsr;
  logic             req_off, req_bad;
  logic             accept;
  logic [INIT_W:0]  init_rnd;
  logic [LCW-1:0]   run_cnt;

  scp_req_check #(.NPL(NPL), .DW(DW), .SRC_W(SRC_W)) u_chk (
    .mask  (plane_mask),
    .src_w (src_w),
    .src_h (src_h),
    .dst_w (dst_w),
    .dst_h (dst_h),
    .off   (req_off),
    .bad   (req_bad)
  );

  scp_opnd_sel #(.DW(DW), .FRAC(FRAC), .PH_BITS(PH_BITS), .PH_FRAC(PH_FRAC)) u_sel (
    .op    (op),
    .src_w (r_src_w),
    .src_h (r_src_h),
    .dst_w (out_w),
    .dst_h (out_h),
    .in_w  (in_w),
    .in_h  (in_h),
    .dvd   (dvd),
    .dsr   (dsr)
  );

  scp_divider #(.NW(NW), .DSW(SRC_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .ld       (div_ld),
    .dividend (dvd),
    .divisor  (dsr),
    .fin      (div_fin),
    .quo      (div_q)
  );

  assign accept   = (st == ST_IDLE) && start;
  assign init_rnd = {1'b0, div_q[INIT_W-1:0]} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op       <= OP_HUP;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      scale_en <= 1'b0;
      enh_en   <= 1'b0;
      div_ld   <= 1'b0;
      r_src_w  <= '0;
      r_src_h  <= '0;
      h_up     <= '0;
      v_up     <= '0;
      h_init   <= '0;
      v_init   <= '0;
      h_step   <= '0;
      v_step   <= '0;
      in_w     <= '0;
      in_h     <= '0;
      out_w    <= '0;
      out_h    <= '0;
    end else begin
      done   <= 1'b0;
      div_ld <= 1'b0;
      if (accept) begin
        err      <= 1'b0;
        scale_en <= 1'b0;
        enh_en   <= 1'b0;
        h_up     <= '0;
        v_up     <= '0;
        h_init   <= '0;
        v_init   <= '0;
        h_step   <= '0;
        v_step   <= '0;
        in_w     <= '0;
        in_h     <= '0;
        out_w    <= '0;
        out_h    <= '0;
        r_src_w  <= '0;
        r_src_h  <= '0;
        if (req_off) begin
          done <= 1'b1;
        end else if (req_bad) begin
          done <= 1'b1;
          err  <= 1'b1;
        end else begin
          r_src_w <= src_w;
          r_src_h <= src_h;
          in_w    <= rotate ? src_h[SRC_W-1:FRAC] : src_w[SRC_W-1:FRAC];
          in_h    <= rotate ? src_w[SRC_W-1:FRAC] : src_h[SRC_W-1:FRAC];
          out_w   <= dst_w;
          out_h   <= dst_h;
          op      <= OP_HUP;
          busy    <= 1'b1;
          div_ld  <= 1'b1;
          st      <= ST_RUN;
        end
      end else if (st == ST_RUN && div_fin) begin
        unique case (op)
          OP_HUP:   h_up   <= div_q[UP_W-1:0];
          OP_VUP:   v_up   <= div_q[UP_W-1:0];
          OP_HINIT: h_init <= init_rnd[INIT_W:1];
          OP_HSTEP: h_step <= div_q[STEP_W-1:0];
          OP_VINIT: v_init <= init_rnd[INIT_W:1];
          OP_VSTEP: v_step <= div_q[STEP_W-1:0];
          default:  ;
        endcase
        if (op == OP_VSTEP) begin
          st       <= ST_IDLE;
          busy     <= 1'b0;
          done     <= 1'b1;
          scale_en <= 1'b1;
          enh_en   <= (h_up[UP_W-1:FRAC] >= ENH_MIN) || (v_up[UP_W-1:FRAC] >= ENH_MIN);
        end else begin
          op     <= op_e'(op + 3'd1);
          div_ld <= 1'b1;
        end
      end
    end
  end

  // Cycle counter used only to bound the run length
  always_ff @(posedge clk) begin
    if (rst)         run_cnt <= '0;
    else if (accept) run_cnt <= '0;
    else if (busy)   run_cnt <= run_cnt + 1'b1;
  end

  AST_OFF_FAST: assert property (@(posedge clk) disable iff (rst)
    (accept && plane_mask == '0) |=> (done && !scale_en && !err && !busy)); // R2

  AST_MULTI_ERR: assert property (@(posedge clk) disable iff (rst)
    (accept && $countones(plane_mask) > 1) |=> (done && err && !scale_en)); // R3

  AST_ZERO_DIM_ERR: assert property (@(posedge clk) disable iff (rst)
    (accept && $countones(plane_mask) == 1 &&
     (dst_w == '0 || dst_h == '0 || src_w == '0 || src_h == '0))
    |=> (done && err && !scale_en)); // R4

  AST_FIXED_LAT: assert property (@(posedge clk) disable iff (rst)
    (done && scale_en) |-> (run_cnt == LCW'(LAT))); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R11

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(out_w) && $stable(out_h) && $stable(in_w) && $stable(in_h))); // R12

  AST_ERR_NO_SCALE: assert property (@(posedge clk) disable iff (rst)
    err |-> !scale_en); // R10
endmodule

// File: tb/scaler_phase_calc_test.sv
module scaler_phase_calc_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int NPL = 4;
  localparam int LAT_OK = 6 * (DW + 32 + 2) + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [NPL-1:0] plane_mask = '0;
  logic rotate = 1'b0;
  logic [31:0] src_w = '0, src_h = '0;
  logic [DW-1:0] dst_w = '0, dst_h = '0;
  logic busy, done, err, scale_en, enh_en;
  logic [31:0] h_up, v_up, h_step, v_step;
  logic [19:0] h_init, v_init;
  logic [DW-1:0] in_w, in_h, out_w, out_h;

  int nchk = 0;
  int nbad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scaler_phase_calc uut (
    .clk(clk), .rst(rst), .start(start), .plane_mask(plane_mask), .rotate(rotate),
    .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
    .busy(busy), .done(done), .err(err), .scale_en(scale_en), .enh_en(enh_en),
    .h_up(h_up), .v_up(v_up), .h_init(h_init), .v_init(v_init),
    .h_step(h_step), .v_step(v_step), .in_w(in_w), .in_h(in_h),
    .out_w(out_w), .out_h(out_h)
  );

  task automatic chk(input bit ok, input string tag, input longint unsigned act,
                     input longint unsigned exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned up_f(longint unsigned d, longint unsigned s);
    return ((d << 32) / s) & 64'hFFFF_FFFF;
  endfunction
  function automatic longint unsigned init_f(longint unsigned i, longint unsigned o);
    return (((i << 4) / o) + 1) / 2;
  endfunction
  function automatic longint unsigned step_f(longint unsigned i, longint unsigned o);
    return (i << 16) / o;
  endfunction

  // kind: 0 valid, 1 disabled (zero mask), 2 rejected
  task automatic run_req(input logic [NPL-1:0] m, input bit rot, input logic [31:0] sw,
                         input logic [31:0] sh, input logic [DW-1:0] dw,
                         input logic [DW-1:0] dh, input int kind, input bit poke);
    int n;
    longint unsigned ew, eh, ehu, evu;
    bit eenh;
    plane_mask = m; rotate = rot; src_w = sw; src_h = sh; dst_w = dw; dst_h = dh;
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 2000) begin
      if (poke && n == 40) begin
        // R12: a new request during busy with other inputs
        start = 1'b1; plane_mask = 4'b0011; dst_w = 16'd7; src_w = 32'h0003_0000;
        rotate = ~rot;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    if (kind == 0) begin
      ew  = rot ? longint'(sh[31:16]) : longint'(sw[31:16]);
      eh  = rot ? longint'(sw[31:16]) : longint'(sh[31:16]);
      ehu = up_f(dw, sw);
      evu = up_f(dh, sh);
      eenh = (ehu[31:16] >= 2) || (evu[31:16] >= 2);
      chk(n == LAT_OK, "R11 latency", n, LAT_OK);
      chk(!busy, "R11 busy low at done", busy, 0);
      chk(scale_en && !err, "R10 scale_en/err", {scale_en, err}, 2);
      chk(out_w == dw && out_h == dh, "R10 out size", {out_w, out_h}, {dw, dh});
      chk(in_w == ew && in_h == eh, "R6 in size", {in_w, in_h}, {ew[15:0], eh[15:0]});
      chk(h_up == ehu, "R5 h_up", h_up, ehu);
      chk(v_up == evu, "R5 v_up", v_up, evu);
      chk(h_init == init_f(ew, dw), "R7 h_init", h_init, init_f(ew, dw));
      chk(v_init == init_f(eh, dh), "R7 v_init", v_init, init_f(eh, dh));
      chk(h_step == step_f(ew, dw), "R8 h_step", h_step, step_f(ew, dw));
      chk(v_step == step_f(eh, dh), "R8 v_step", v_step, step_f(eh, dh));
      chk(enh_en == eenh, "R9 enh_en", enh_en, eenh);
      if (poke) chk(n == LAT_OK && h_up == ehu, "R12 run unaffected", n, LAT_OK);
    end else if (kind == 1) begin
      chk(n == 1, "R2 latency", n, 1);
      chk(!scale_en && !err && !busy, "R2 flags", {scale_en, err, busy}, 0);
      chk(h_up == 0 && v_step == 0 && out_w == 0, "R2 results zero", h_up, 0);
    end else begin
      chk(n == 1, "R3/R4 latency", n, 1);
      chk(err && !scale_en, "R3/R4 err flag", {err, scale_en}, 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd24681357);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done && !err && !scale_en && !enh_en, "R1 reset",
        {busy, done, err, scale_en, enh_en}, 0);
    rst = 1'b0;
    @(negedge clk);
    // R2 zero mask, even with zero dimensions
    run_req(4'b0000, 1'b0, 32'h0, 32'h0, 16'd0, 16'd0, 1, 1'b0);
    // R3 two planes selected
    run_req(4'b0101, 1'b0, 32'h0010_0000, 32'h0010_0000, 16'd32, 16'd32, 2, 1'b0);
    run_req(4'b1111, 1'b1, 32'h0010_0000, 32'h0010_0000, 16'd32, 16'd32, 2, 1'b0);
    // R4 zero dimensions
    run_req(4'b0001, 1'b0, 32'h0010_0000, 32'h0010_0000, 16'd0, 16'd32, 2, 1'b0);
    run_req(4'b0010, 1'b0, 32'h0010_0000, 32'h0, 16'd32, 16'd32, 2, 1'b0);
    // R6 rotation, R9 enhancer on (2x up)
    run_req(4'b0100, 1'b1, 32'h0040_0000, 32'h0020_0000, 16'd128, 16'd64, 0, 1'b0);
    // R9 enhancer off: downscale, no rotation
    run_req(4'b1000, 1'b0, 32'h0100_0000, 32'h0080_8000, 16'd100, 16'd60, 0, 1'b0);
    // R9 boundary: just under 2x
    run_req(4'b0001, 1'b0, 32'h0064_0000, 32'h0064_0000, 16'd199, 16'd100, 0, 1'b0);
    // Largest quotients
    run_req(4'b0001, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'hFFFF, 16'd1, 0, 1'b0);
    run_req(4'b0010, 1'b1, 32'hFFFF_0000, 32'h0001_0000, 16'd1, 16'hFFFF, 0, 1'b0);
    // R12 start during busy
    run_req(4'b0010, 1'b0, 32'h0030_0000, 32'h0018_0000, 16'd90, 16'd50, 0, 1'b1);
    // Random requests, chained back to back
    for (int k = 0; k < 30; k++) begin
      logic [31:0] rsw, rsh;
      logic [DW-1:0] rdw, rdh;
      rsw = $urandom;
      rsh = $urandom;
      if (k % 2 == 0) begin
        rsw = rsw & 32'h03FF_FFFF;
        rsh = rsh & 32'h03FF_FFFF;
      end
      if (rsw == 0) rsw = 32'h0001_0000;
      if (rsh == 0) rsh = 32'h0001_0000;
      rdw = DW'($urandom_range(1, (k % 3 == 0) ? 65535 : 2048));
      rdh = DW'($urandom_range(1, (k % 3 == 1) ? 65535 : 2048));
      run_req(4'(1 << $urandom_range(0, NPL-1)), 1'($urandom_range(0, 1)),
              rsw, rsh, rdw, rdh, 0, 1'b0);
    end
    // Disabled request after a valid one clears results (R2)
    run_req(4'b0000, 1'b1, 32'h0010_0000, 32'h0010_0000, 16'd8, 16'd8, 1, 1'b0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule